// File: doc/BRIEF.md
# In-Flight Memory Request Tracker

The tracker sits between a processor's request port and the request queue of a cache controller. It keeps every memory request that has been sent on but not yet answered. Reads (loads and instruction fetches) go into a read table. Writes (stores, locked reads and locked writes) go into a write table. Both tables are keyed by cache-line address. A new request is accepted or refused in the same cycle it is presented. An accepted request is sent on one cycle later, with a reduced command code, a folded access mode and an identifier taken from a free-running counter.

A completion names a line and says whether it answers a read or a write. A matching entry is freed, and the tracker returns that entry's identifier and the number of cycles it was pending. A completion with no matching entry raises an error pulse and frees nothing. A periodic watchdog is armed by the first insertion into an idle tracker and checks the tables every threshold period. It pulses a flag when any entry has been pending for at least the threshold, and it disarms once both tables are empty.

Top module: `inflight_tracker`

## Requirements
- R1: `reqReady` is low while the number of pending entries in both tables together is at or above `MAX_OUT` (default 6).
- R2: `reqReady` is low while the request's line (`reqAddr >> log2(LINE_BYTES)`) is pending in either table, so at most one request per line is in flight.
- R3: `reqKind` codes are 0 fetch, 1 load, 2 store, 3 locked read and 4 locked write. Kinds 0 and 1 use the read table and kinds 2 to 4 use the write table. A completion with `doneIsWrite`=0 searches only the read table, and one with `doneIsWrite`=1 searches only the write table.
- R4: the outstanding count always equals the number of occupied entries. A request whose destination table already holds `RD_DEPTH` or `WR_DEPTH` entries is refused.
- R5: one cycle after an acceptance, `fwdValid` is 1 with `fwdLine`. `fwdCmd` is 0 for kinds 0 to 2 and 1 (atomic) for kinds 3 and 4. `reqMode` codes are 0 user, 1 supervisor and 2 device; `fwdMode` is 1 only for supervisor, and device is sent on as user (0).
- R6: a request is illegal when `reqAddr % LINE_BYTES + reqLen > LINE_BYTES`, when its kind is 5 to 7, or when its mode is 3. `reqIllegal` is then high in the same cycle and `reqReady` is low.
- R7: identifiers start at 0 after reset and increase by one, modulo 2^ID_W, for each accepted request.
- R8: one cycle after a matching completion, `rspValid` is 1 with the entry's `rspId`, and `rspLatency` is the completion cycle minus the acceptance cycle. The entry is freed.
- R9: a completion that matches no entry in its table pulses `doneErr` one cycle later, produces no `rspValid` and frees nothing.
- R10: the watchdog is armed by an acceptance while it is disarmed, and it checks the tables THRESH cycles later and every THRESH cycles after that. At each check it re-arms if entries remain and disarms otherwise. `stuckFlag` pulses in the cycle after a check that finds an entry whose age is at least THRESH.
- R11: a request and a completion for the same line in the same cycle are judged on the tables as they were before the completion, so the request is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | New request present |
| reqAddr | input | ADDR_W | Byte address of the request |
| reqKind | input | 3 | Request kind code |
| reqMode | input | 2 | Access mode code |
| reqLen | input | LEN_W | Access length in bytes |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqIllegal | output | 1 | Presented request is illegal |
| fwdValid | output | 1 | Request sent on to the cache controller |
| fwdLine | output | ADDR_W-log2(LINE_BYTES) | Line address sent on |
| fwdCmd | output | 1 | 0 plain access, 1 atomic |
| fwdMode | output | 1 | 0 user, 1 supervisor |
| fwdId | output | ID_W | Identifier assigned |
| doneValid | input | 1 | Completion present |
| doneIsWrite | input | 1 | Completion answers the write table |
| doneLine | input | ADDR_W-log2(LINE_BYTES) | Line address completed |
| rspValid | output | 1 | Completion matched an entry |
| rspId | output | ID_W | Identifier of the completed entry |
| rspLatency | output | TIME_W | Cycles the entry was pending |
| doneErr | output | 1 | Completion matched nothing |
| stuckFlag | output | 1 | Watchdog found an over-age entry |

## Verification
`reqReady` and `reqIllegal` are combinational, so the bench checks them one time step after it drives the inputs, before the next rising edge. The forwarded request, the completion response, `doneErr` and `stuckFlag` are all registered once, so the results of the inputs driven in one bench step are compared at the start of the next step, before new inputs are applied. The watchdog pulse is expected THRESH+1 steps after the arming acceptance. The bench's reference model keeps its own copy of the armed state and the period count, and checks `stuckFlag` for exactly that step on every step.

// File: rtl/trk_pkg.sv
package trk_pkg;

  localparam logic [2:0] KIND_FETCH  = 3'd0;
  localparam logic [2:0] KIND_LOAD   = 3'd1;
  localparam logic [2:0] KIND_STORE  = 3'd2;
  localparam logic [2:0] KIND_LOCKRD = 3'd3;
  localparam logic [2:0] KIND_LOCKWR = 3'd4;

  localparam logic [1:0] MODE_USER   = 2'd0;
  localparam logic [1:0] MODE_SUPER  = 2'd1;
  localparam logic [1:0] MODE_DEVICE = 2'd2;

  localparam logic CMD_ACCESS = 1'b0;
  localparam logic CMD_ATOMIC = 1'b1;

  // strobes from control to datapath
  typedef struct packed {
    logic insRd;
    logic insWr;
    logic relRd;
    logic relWr;
  } trk_strobe_t;

endpackage

// File: rtl/trk_table.sv
module trk_table #(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 12,
  parameter int ID_W   = 8,
  parameter int TIME_W = 16,
  parameter int THRESH = 40,
  localparam int OCC_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINE_W-1:0] lookLine,
  output logic              lookHit,
  output logic              full,
  input  logic              ins,
  input  logic [ID_W-1:0]   insId,
  input  logic [TIME_W-1:0] nowTime,
  input  logic [LINE_W-1:0] relLine,
  output logic              relHit,
  input  logic              rel,
  output logic [ID_W-1:0]   relId,
  output logic [TIME_W-1:0] relIssue,
  output logic [OCC_W-1:0]  occ,
  output logic              stale
);

  logic [DEPTH-1:0]  vld;
  logic [LINE_W-1:0] lineQ  [DEPTH];
  logic [ID_W-1:0]   idQ    [DEPTH];
  logic [TIME_W-1:0] issueQ [DEPTH];

  logic [DEPTH-1:0] hitVec, relVec, staleVec;
  logic [IDX_W-1:0] freeIdx, relIdx;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hitVec[i]   = vld[i] && (lineQ[i] == lookLine);
      relVec[i]   = vld[i] && (lineQ[i] == relLine);
      staleVec[i] = vld[i] && ((nowTime - issueQ[i]) >= TIME_W'(THRESH));
    end
  end

  // lowest free slot and lowest matching slot
  always_comb begin
    freeIdx = '0;
    relIdx  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld[i])   freeIdx = IDX_W'(i);
      if (relVec[i]) relIdx  = IDX_W'(i);
    end
  end

  always_comb begin
    occ = '0;
    for (int i = 0; i < DEPTH; i++) occ = occ + OCC_W'(vld[i]);
  end

  assign lookHit  = |hitVec;
  assign relHit   = |relVec;
  assign full     = &vld;
  assign stale    = |staleVec;
  assign relId    = idQ[relIdx];
  assign relIssue = issueQ[relIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld <= '0;
    end else begin
      if (rel && relHit) vld[relIdx] <= 1'b0;
      if (ins && !full)  vld[freeIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins && !full) begin
      lineQ[freeIdx]  <= lookLine;
      idQ[freeIdx]    <= insId;
      issueQ[freeIdx] <= nowTime;
    end
  end

  assert_one_per_line_R2: assert property (@(posedge clk) disable iff (!rstN)
    ins |-> !lookHit);
  assert_room_on_insert_R4: assert property (@(posedge clk) disable iff (!rstN)
    ins |-> !full);
  assert_release_hits_R9: assert property (@(posedge clk) disable iff (!rstN)
    rel |-> relHit);
  assert_release_frees_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rel && !ins) |=> (occ == $past(occ) - OCC_W'(1)));

endmodule

// File: rtl/trk_datapath.sv
module trk_datapath
  import trk_pkg::*;
#(
  parameter int RD_DEPTH = 4,
  parameter int WR_DEPTH = 4,
  parameter int LINE_W   = 12,
  parameter int ID_W     = 8,
  parameter int TIME_W   = 16,
  parameter int THRESH   = 40,
  localparam int RD_OCC_W = $clog2(RD_DEPTH + 1),
  localparam int WR_OCC_W = $clog2(WR_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  trk_strobe_t         stb,
  input  logic [LINE_W-1:0]   reqLine,
  input  logic [LINE_W-1:0]   doneLine,
  input  logic [ID_W-1:0]     insId,
  output logic                rdHit,
  output logic                wrHit,
  output logic                rdFull,
  output logic                wrFull,
  output logic [RD_OCC_W-1:0] rdOcc,
  output logic [WR_OCC_W-1:0] wrOcc,
  output logic                doneRdHit,
  output logic                doneWrHit,
  output logic                anyStale,
  output logic                rspValid,
  output logic [ID_W-1:0]     rspId,
  output logic [TIME_W-1:0]   rspLatency
);

  logic [TIME_W-1:0] nowTime;
  logic [ID_W-1:0]   rdRelId, wrRelId;
  logic [TIME_W-1:0] rdIssue, wrIssue;
  logic              rdStale, wrStale;

  always_ff @(posedge clk) begin
    if (!rstN) nowTime <= '0;
    else       nowTime <= nowTime + TIME_W'(1);
  end

  trk_table #(
    .DEPTH(RD_DEPTH), .LINE_W(LINE_W), .ID_W(ID_W), .TIME_W(TIME_W), .THRESH(THRESH)
  ) u_rdTable (
    .clk(clk), .rstN(rstN), .lookLine(reqLine), .lookHit(rdHit), .full(rdFull),
    .ins(stb.insRd), .insId(insId), .nowTime(nowTime), .relLine(doneLine),
    .relHit(doneRdHit), .rel(stb.relRd), .relId(rdRelId), .relIssue(rdIssue),
    .occ(rdOcc), .stale(rdStale)
  );

  trk_table #(
    .DEPTH(WR_DEPTH), .LINE_W(LINE_W), .ID_W(ID_W), .TIME_W(TIME_W), .THRESH(THRESH)
  ) u_wrTable (
    .clk(clk), .rstN(rstN), .lookLine(reqLine), .lookHit(wrHit), .full(wrFull),
    .ins(stb.insWr), .insId(insId), .nowTime(nowTime), .relLine(doneLine),
    .relHit(doneWrHit), .rel(stb.relWr), .relId(wrRelId), .relIssue(wrIssue),
    .occ(wrOcc), .stale(wrStale)
  );

  assign anyStale = rdStale | wrStale;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspId      <= '0;
      rspLatency <= '0;
    end else begin
      rspValid <= stb.relRd | stb.relWr;
      if (stb.relRd) begin
        rspId      <= rdRelId;
        rspLatency <= nowTime - rdIssue;
      end else if (stb.relWr) begin
        rspId      <= wrRelId;
        rspLatency <= nowTime - wrIssue;
      end
    end
  end

  assert_single_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.relRd && stb.relWr));
  assert_latency_nonzero_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspLatency != '0));

endmodule

// File: rtl/trk_ctrl.sv
module trk_ctrl
  import trk_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 16,
  parameter int LEN_W      = 5,
  parameter int RD_DEPTH   = 4,
  parameter int WR_DEPTH   = 4,
  parameter int MAX_OUT    = 6,
  parameter int ID_W       = 8,
  parameter int THRESH     = 40,
  localparam int OFF_W    = $clog2(LINE_BYTES),
  localparam int LINE_W   = ADDR_W - OFF_W,
  localparam int RD_OCC_W = $clog2(RD_DEPTH + 1),
  localparam int WR_OCC_W = $clog2(WR_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [2:0]          reqKind,
  input  logic [1:0]          reqMode,
  input  logic [LEN_W-1:0]    reqLen,
  output logic                reqReady,
  output logic                reqIllegal,
  input  logic                doneValid,
  input  logic                doneIsWrite,
  input  logic                rdHit,
  input  logic                wrHit,
  input  logic                rdFull,
  input  logic                wrFull,
  input  logic [RD_OCC_W-1:0] rdOcc,
  input  logic [WR_OCC_W-1:0] wrOcc,
  input  logic                doneRdHit,
  input  logic                doneWrHit,
  input  logic                anyStale,
  output trk_strobe_t         stb,
  output logic [ID_W-1:0]     idCnt,
  output logic                fwdValid,
  output logic [LINE_W-1:0]   fwdLine,
  output logic                fwdCmd,
  output logic                fwdMode,
  output logic [ID_W-1:0]     fwdId,
  output logic                doneErr,
  output logic                stuckFlag
);

  localparam int CNT_W  = $clog2(MAX_OUT + 1);
  localparam int SPAN_W = ((OFF_W > LEN_W) ? OFF_W : LEN_W) + 1;
  localparam int WD_W   = $clog2(THRESH);

  logic [CNT_W-1:0]  outCnt, nextCnt;
  logic [WD_W-1:0]   wdCnt;
  logic              armed, wdCheck;
  logic [SPAN_W-1:0] span;
  logic              badSize, badKind, badMode, illegal;
  logic              toWrite, dstFull, accept, doneHit, release_;

  // request legality
  assign span    = SPAN_W'(reqAddr[OFF_W-1:0]) + SPAN_W'(reqLen);
  assign badSize = span > SPAN_W'(LINE_BYTES);
  assign badKind = reqKind > KIND_LOCKWR;
  assign badMode = reqMode == 2'd3;
  assign illegal = badSize | badKind | badMode;

  assign toWrite = (reqKind == KIND_STORE) || (reqKind == KIND_LOCKRD) ||
                   (reqKind == KIND_LOCKWR);
  assign dstFull = toWrite ? wrFull : rdFull;

  assign reqReady   = !illegal && (outCnt < CNT_W'(MAX_OUT)) && !rdHit && !wrHit && !dstFull;
  assign reqIllegal = reqValid && illegal;
  assign accept     = reqValid && reqReady;

  // completion matching
  assign doneHit  = doneIsWrite ? doneWrHit : doneRdHit;
  assign release_ = doneValid && doneHit;

  always_comb begin
    stb       = '0;
    stb.insRd = accept && !toWrite;
    stb.insWr = accept && toWrite;
    stb.relRd = release_ && !doneIsWrite;
    stb.relWr = release_ && doneIsWrite;
  end

  assign nextCnt = outCnt + CNT_W'(accept) - CNT_W'(release_);
  assign wdCheck = armed && (wdCnt == WD_W'(THRESH - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outCnt <= '0;
      idCnt  <= '0;
    end else begin
      outCnt <= nextCnt;
      if (accept) idCnt <= idCnt + ID_W'(1);
    end
  end

  // forwarded request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdValid <= 1'b0;
      fwdLine  <= '0;
      fwdCmd   <= CMD_ACCESS;
      fwdMode  <= 1'b0;
      fwdId    <= '0;
    end else begin
      fwdValid <= accept;
      if (accept) begin
        fwdLine <= reqAddr[ADDR_W-1:OFF_W];
        fwdCmd  <= ((reqKind == KIND_LOCKRD) || (reqKind == KIND_LOCKWR)) ? CMD_ATOMIC : CMD_ACCESS;
        fwdMode <= (reqMode == MODE_SUPER);
        fwdId   <= idCnt;
      end
    end
  end

  // watchdog period timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed     <= 1'b0;
      wdCnt     <= '0;
      stuckFlag <= 1'b0;
      doneErr   <= 1'b0;
    end else begin
      stuckFlag <= wdCheck && anyStale;
      doneErr   <= doneValid && !doneHit;
      if (wdCheck) begin
        armed <= (nextCnt != '0);
        wdCnt <= '0;
      end else if (armed) begin
        wdCnt <= wdCnt + WD_W'(1);
      end else if (accept) begin
        armed <= 1'b1;
        wdCnt <= '0;
      end
    end
  end

  assert_count_cap_R1: assert property (@(posedge clk) disable iff (!rstN)
    outCnt <= CNT_W'(MAX_OUT));
  assert_count_matches_R4: assert property (@(posedge clk) disable iff (!rstN)
    int'(outCnt) == int'(rdOcc) + int'(wrOcc));
  assert_forward_follows_R5: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> fwdValid);
  assert_illegal_refused_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqIllegal |-> !reqReady);
  assert_id_advances_R7: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (idCnt == $past(idCnt) + ID_W'(1)));
  assert_error_no_free_R9: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !doneHit && !accept) |=> $stable(outCnt));
  assert_stuck_needs_arm_R10: assert property (@(posedge clk) disable iff (!rstN)
    stuckFlag |-> $past(armed));

endmodule

// File: rtl/inflight_tracker.sv
module inflight_tracker
  import trk_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 16,
  parameter int LEN_W      = 5,
  parameter int RD_DEPTH   = 4,
  parameter int WR_DEPTH   = 4,
  parameter int MAX_OUT    = 6,
  parameter int ID_W       = 8,
  parameter int TIME_W     = 16,
  parameter int THRESH     = 40,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqKind,
  input  logic [1:0]        reqMode,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              reqReady,
  output logic              reqIllegal,
  output logic              fwdValid,
  output logic [LINE_W-1:0] fwdLine,
  output logic              fwdCmd,
  output logic              fwdMode,
  output logic [ID_W-1:0]   fwdId,
  input  logic              doneValid,
  input  logic              doneIsWrite,
  input  logic [LINE_W-1:0] doneLine,
  output logic              rspValid,
  output logic [ID_W-1:0]   rspId,
  output logic [TIME_W-1:0] rspLatency,
  output logic              doneErr,
  output logic              stuckFlag
);

  localparam int RD_OCC_W = $clog2(RD_DEPTH + 1);
  localparam int WR_OCC_W = $clog2(WR_DEPTH + 1);

  trk_strobe_t         stb;
  logic [ID_W-1:0]     idCnt;
  logic                rdHit, wrHit, rdFull, wrFull, doneRdHit, doneWrHit, anyStale;
  logic [RD_OCC_W-1:0] rdOcc;
  logic [WR_OCC_W-1:0] wrOcc;
  logic [LINE_W-1:0]   reqLine;

  assign reqLine = reqAddr[ADDR_W-1:OFF_W];

  trk_ctrl #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W), .RD_DEPTH(RD_DEPTH),
    .WR_DEPTH(WR_DEPTH), .MAX_OUT(MAX_OUT), .ID_W(ID_W), .THRESH(THRESH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqKind(reqKind),
    .reqMode(reqMode), .reqLen(reqLen), .reqReady(reqReady), .reqIllegal(reqIllegal),
    .doneValid(doneValid), .doneIsWrite(doneIsWrite), .rdHit(rdHit), .wrHit(wrHit),
    .rdFull(rdFull), .wrFull(wrFull), .rdOcc(rdOcc), .wrOcc(wrOcc),
    .doneRdHit(doneRdHit), .doneWrHit(doneWrHit), .anyStale(anyStale), .stb(stb),
    .idCnt(idCnt), .fwdValid(fwdValid), .fwdLine(fwdLine), .fwdCmd(fwdCmd),
    .fwdMode(fwdMode), .fwdId(fwdId), .doneErr(doneErr), .stuckFlag(stuckFlag)
  );

  trk_datapath #(
    .RD_DEPTH(RD_DEPTH), .WR_DEPTH(WR_DEPTH), .LINE_W(LINE_W), .ID_W(ID_W),
    .TIME_W(TIME_W), .THRESH(THRESH)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqLine(reqLine), .doneLine(doneLine),
    .insId(idCnt), .rdHit(rdHit), .wrHit(wrHit), .rdFull(rdFull), .wrFull(wrFull),
    .rdOcc(rdOcc), .wrOcc(wrOcc), .doneRdHit(doneRdHit), .doneWrHit(doneWrHit),
    .anyStale(anyStale), .rspValid(rspValid), .rspId(rspId), .rspLatency(rspLatency)
  );

endmodule

// File: tb/inflight_tracker_tb.sv
module inflight_tracker_tb;

  localparam int ADDR_W = 16, LINE_BYTES = 16, LEN_W = 5, RD_D = 4, WR_D = 4;
  localparam int MAXO = 6, ID_W = 8, TIME_W = 16, THRESH = 40, LINE_W = 12, NE = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, doneValid = 0, doneIsWrite = 0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [2:0] reqKind = '0;
  logic [1:0] reqMode = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic [LINE_W-1:0] doneLine = '0;
  logic reqReady, reqIllegal, fwdValid, fwdCmd, fwdMode, rspValid, doneErr, stuckFlag;
  logic [LINE_W-1:0] fwdLine;
  logic [ID_W-1:0] fwdId, rspId;
  logic [TIME_W-1:0] rspLatency;

  always #4 clk = ~clk;

  inflight_tracker #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W), .RD_DEPTH(RD_D),
    .WR_DEPTH(WR_D), .MAX_OUT(MAXO), .ID_W(ID_W), .TIME_W(TIME_W), .THRESH(THRESH)
  ) u_dut (.*);

  int nChk = 0, nBad = 0, cyc = 0;
  bit mVld[NE]; int mLine[NE]; bit mWr[NE]; int mId[NE]; int mIssue[NE];
  bit eFwdV, eFwdCmd, eFwdMode, eRspV, eErr, eStuck, wdArmed;
  int eFwdLine, eFwdId, eRspId, eRspLat, wdCnt, idNext;

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d (step %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bit isIllegal(int addr, int kind, int mode, int len);
    return ((addr % LINE_BYTES) + len > LINE_BYTES) || (kind > 4) || (mode == 3);
  endfunction

  task automatic step(bit rv, int addr, int kind, int mode, int len, bit dv, bit dw, int dline);
    int cnt, rdC, wrC, idx, fr, postCnt;
    bit hit, found, ill, toWr, full, rdy, acc, chkNow, stale, sameLine;
    string tg;
    @(negedge clk);
    cyc++;
    chk("R5 fwdValid", fwdValid, eFwdV);
    if (eFwdV) begin
      chk("R5 fwdLine", fwdLine, eFwdLine);
      chk("R7 fwdId", fwdId, eFwdId);
      chk("R5 fwdCmd", fwdCmd, eFwdCmd);
      chk("R5 fwdMode", fwdMode, eFwdMode);
    end
    chk("R8 rspValid", rspValid, eRspV);
    if (eRspV) begin
      chk("R8 rspId", rspId, eRspId);
      chk("R8 rspLatency", rspLatency, eRspLat);
    end
    chk("R9 doneErr", doneErr, eErr);
    chk("R10 stuckFlag", stuckFlag, eStuck);
    reqValid = rv; reqAddr = ADDR_W'(addr); reqKind = 3'(kind); reqMode = 2'(mode);
    reqLen = LEN_W'(len); doneValid = dv; doneIsWrite = dw; doneLine = LINE_W'(dline);
    #1;
    cnt = 0; rdC = 0; wrC = 0; hit = 0; found = 0; idx = 0; stale = 0; fr = 0;
    for (int i = 0; i < NE; i++) if (mVld[i]) begin
      cnt++;
      if (mWr[i]) wrC++; else rdC++;
      if (mLine[i] == addr / LINE_BYTES) hit = 1;
      if (!found && mLine[i] == dline && mWr[i] == dw) begin found = 1; idx = i; end
      if (cyc - mIssue[i] >= THRESH) stale = 1;
    end
    ill = isIllegal(addr, kind, mode, len);
    toWr = (kind >= 2 && kind <= 4);
    full = toWr ? (wrC >= WR_D) : (rdC >= RD_D);
    rdy = !ill && cnt < MAXO && !hit && !full;
    sameLine = dv && found && (dline == addr / LINE_BYTES);
    tg = ill ? "R6 reqReady" : (cnt >= MAXO) ? "R1 reqReady" : sameLine ? "R11 reqReady" :
         hit ? "R2 reqReady" : full ? "R4 reqReady" : "R3 reqReady";
    chk(tg, reqReady, rdy);
    chk("R6 reqIllegal", reqIllegal, rv && ill);
    acc = rv && rdy;
    // expected registered results for the next step
    eFwdV = acc;
    if (acc) begin
      eFwdLine = addr / LINE_BYTES; eFwdId = idNext;
      eFwdCmd = (kind == 3 || kind == 4); eFwdMode = (mode == 1);
    end
    eRspV = dv && found;
    if (eRspV) begin eRspId = mId[idx]; eRspLat = cyc - mIssue[idx]; end
    eErr = dv && !found;
    chkNow = wdArmed && (wdCnt == THRESH - 1);
    eStuck = chkNow && stale;
    postCnt = cnt + int'(acc) - int'(dv && found);
    if (chkNow) begin wdArmed = (postCnt != 0); wdCnt = 0; end
    else if (wdArmed) wdCnt++;
    else if (acc) begin wdArmed = 1; wdCnt = 0; end
    if (dv && found) mVld[idx] = 0;
    if (acc) begin
      for (int i = NE - 1; i >= 0; i--) if (!mVld[i]) fr = i;
      mVld[fr] = 1; mLine[fr] = addr / LINE_BYTES; mWr[fr] = toWr;
      mId[fr] = idNext; mIssue[fr] = cyc;
      idNext = (idNext + 1) % 256;
    end
  endtask

  task automatic req(int line, int off, int kind, int mode, int len);
    step(1, line * LINE_BYTES + off, kind, mode, len, 0, 0, 0);
  endtask
  task automatic idle(int n);
    repeat (n) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic fin(int line, bit wr);
    step(0, 0, 0, 0, 0, 1, wr, line);
  endtask
  task automatic drain();
    for (int i = 0; i < NE; i++) if (mVld[i]) fin(mLine[i], mWr[i]);
    idle(2 * THRESH + 2);
  endtask

  task automatic randomPhase(int n);
    int pick[NE]; int np, old, oldAge, line, off, len, kind, mode, dl;
    bit dv, dw, rv;
    for (int k = 0; k < n; k++) begin
      np = 0; old = -1; oldAge = -1;
      for (int i = 0; i < NE; i++) if (mVld[i]) begin
        pick[np] = i; np++;
        if (cyc + 1 - mIssue[i] > oldAge) begin oldAge = cyc + 1 - mIssue[i]; old = i; end
      end
      dv = 0; dw = 0; dl = 0;
      if (old >= 0 && oldAge >= 15) begin dv = 1; dw = mWr[old]; dl = mLine[old]; end
      else if (np > 0 && $urandom % 2 == 0) begin
        int j = pick[$urandom % np]; dv = 1; dw = mWr[j]; dl = mLine[j];
      end else if ($urandom % 10 == 0) begin
        dv = 1; dw = 1'($urandom % 2); dl = $urandom % 12;
      end
      rv = ($urandom % 4 != 0);
      line = $urandom % 12; off = $urandom % 16;
      len = ($urandom % 10 == 0) ? $urandom % 32 : 1 + $urandom % (16 - off);
      kind = ($urandom % 20 == 0) ? 5 + $urandom % 3 : $urandom % 5;
      mode = ($urandom % 16 == 0) ? 3 : $urandom % 3;
      step(rv, line * LINE_BYTES + off, kind, mode, len, dv, dw, dl);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // reset state: outputs idle, ids start at 0 (R7)
    idle(2);
    // R1: cap on total outstanding
    req(100, 0, 1, 0, 4); req(101, 0, 1, 0, 4); req(102, 0, 0, 0, 4);
    req(103, 0, 2, 0, 4); req(104, 0, 2, 0, 4); req(105, 0, 3, 0, 4);
    req(106, 0, 1, 0, 4);
    drain();
    // R4: write table full while total below the cap
    req(110, 0, 2, 0, 8); req(111, 0, 2, 0, 8); req(112, 0, 4, 0, 8); req(113, 0, 3, 0, 8);
    req(114, 0, 2, 0, 8); req(114, 0, 1, 0, 8);
    drain();
    // R2, R9, R11: one request per line, wrong-table completion, same-cycle overlap
    req(120, 4, 1, 0, 4); req(120, 8, 2, 0, 4);
    fin(120, 1);
    step(1, 120 * LINE_BYTES, 1, 0, 4, 1, 0, 120);
    req(120, 0, 1, 0, 4);
    drain();
    // R6 and R5: legality edges, command and mode folding
    req(130, 15, 1, 0, 2); req(131, 0, 1, 0, 16); req(131, 15, 1, 0, 1);
    req(132, 0, 6, 0, 4); req(133, 0, 1, 3, 4);
    req(134, 0, 3, 2, 4); req(135, 0, 0, 1, 4); req(136, 0, 4, 0, 4); req(137, 0, 2, 2, 4);
    drain();
    // R10: watchdog on a stuck entry, re-arm, then disarm
    req(140, 0, 1, 0, 4);
    idle(2 * THRESH + 5);
    fin(140, 0);
    idle(2 * THRESH + 5);
    // constrained random mix (R3 table routing, R8 latency)
    randomPhase(3000);
    drain();
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nChk++; nBad++;
    $display("FAIL watchdog: run did not end (step %0d)", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule